// File: doc/BRIEF.md
# Sector Cache Tag Lookup and Fill Control

This block is the tag-side lookup and fill control for a set-associative cache. Every line is 512 bits wide and holds eight 64-bit words. Alongside its tag, each line keeps one valid bit per word. A request carries an address and an 8-bit demand vector. Bit i of that vector names word i of the line, which is the word at byte offset 8*i. The block compares the request with every way of the selected set and returns one of three outcomes:

- a sector hit;
- a sector miss, together with the mask of words still to fetch;
- a full miss, when no way holds the tag.

Only one miss can be outstanding. While a miss waits, the block stops accepting requests. When the fill response arrives, the block updates the waiting line and reopens for requests. On a sector miss the returned words are merged into the line. On a full miss a victim way is replaced by a new line.

Address layout is as follows:

- bits [5:0] are the byte offset within the line and have no effect;
- the set index sits directly above the offset;
- the remaining upper bits form the tag.

Replacement chooses the lowest-numbered empty way first. If the set is full, it replaces the way that was not used most recently.

Top module: `sector_cache_lookup`

## Requirements
- R1: After reset every line is empty, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its outcome appears on the following cycle with `rsp_valid` at 1 and exactly one of `rsp_hit`, `rsp_sect_miss`, `rsp_full_miss` at 1. In every other cycle `rsp_valid` and all three flags are 0.
- R3: If a way holds the request tag and every demanded word is valid, the outcome is a sector hit with `rsp_fetch` equal to 0. That way becomes the most recently used way of its set.
- R4: If a way holds the tag but some demanded words are invalid, the outcome is a sector miss. `rsp_fetch` equals the demand vector AND the inverse of that line's valid bits.
- R5: If no way in the set holds the tag, the outcome is a full miss and `rsp_fetch` equals the demand vector.
- R6: After either kind of miss, `req_ready` stays 0 until the edge at which `fill_valid` is sampled, and is 1 from the next cycle on. A request offered while `req_ready` is 0 produces no response.
- R7: A fill that completes a sector miss ORs `fill_sect` into the valid bits of the line that missed.
- R8: A fill that completes a full miss writes the tag into the victim way. The valid bits of that way become exactly `fill_sect`.
- R9: The victim is the lowest-numbered empty way of the set. If no way is empty, the victim is the way other than the most recently used one, where both hits and fills count as uses.
- R10: A `fill_valid` pulse while no miss is outstanding changes nothing.
- R11: The set index is taken from address bits [6+log2(SETS)-1:6], the tag from the bits above it, and bits [5:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request (no miss outstanding) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_sect | input | 8 | Demanded words, bit i = word i |
| rsp_valid | output | 1 | Outcome of the request accepted last cycle |
| rsp_hit | output | 1 | Sector hit |
| rsp_sect_miss | output | 1 | Tag present, some demanded words missing |
| rsp_full_miss | output | 1 | Tag absent from the set |
| rsp_fetch | output | 8 | Words to fetch for the miss, 0 on a hit |
| fill_valid | input | 1 | Fill response for the outstanding miss |
| fill_sect | input | 8 | Words delivered by the fill |

## Verification
The assertions assume three things about the requester:

- a fill is only meaningful while `req_ready` is low;
- requests offered during a stall are simply not taken;
- the demand vector is stable in the cycle a request is accepted.

The outcome checks compare `rsp_fetch` against the demand vector sampled one edge earlier. The bench drives inputs on the falling edge and holds each request for one cycle. It always answers a miss with a single fill pulse. It also deliberately offers an extra request during a stall and a stray fill while idle, so both rejection paths stay inside those assumptions.

// File: rtl/sc_pkg.sv
// Package: shared constants and types for the sector cache lookup block.
// Assumes 64-byte lines split into eight 64-bit words.
package sc_pkg;
    localparam int SECT     = 8;
    localparam int OFFSET_W = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
// Module: sc_tag_store
// Holds tag, line-present bit and per-word valid bits for every way of
// every set, plus the most recently used way per set. Reads one set
// combinationally. One write port (fill) and one touch port (hit).
// Assumes fill writes and hit touches never occur in the same cycle.
module sc_tag_store
    import sc_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 2,
    parameter int TAG_W = 22,
    parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][SECT-1:0]    rd_val,
    output logic [WAYS-1:0]              rd_line,
    output logic [WAY_W-1:0]             rd_mru,
    input  logic                         wr_en,
    input  logic                         wr_replace,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [SECT-1:0]              wr_sect,
    input  logic                         touch_en,
    input  logic [SET_W-1:0]             touch_set,
    input  logic [WAY_W-1:0]             touch_way
);
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [SECT-1:0]  val_q  [SETS][WAYS];
    logic             line_q [SETS][WAYS];
    logic [WAY_W-1:0] mru_q  [SETS];

    // Purpose: present the addressed set on the read port.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w]  = tag_q[rd_set][w];
        assign rd_val[w]  = val_q[rd_set][w];
        assign rd_line[w] = line_q[rd_set][w];
    end
    assign rd_mru = mru_q[rd_set];

    // Purpose: clear on reset, apply fills and hit touches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                mru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    val_q[s][w]  <= '0;
                    line_q[s][w] <= 1'b0;
                end
            end
        end else if (wr_en) begin
            if (wr_replace) begin
                tag_q[wr_set][wr_way]  <= wr_tag;
                val_q[wr_set][wr_way]  <= wr_sect;
                line_q[wr_set][wr_way] <= 1'b1;
            end else begin
                val_q[wr_set][wr_way] <= val_q[wr_set][wr_way] | wr_sect;
            end
            mru_q[wr_set] <= wr_way;
        end else if (touch_en) begin
            mru_q[touch_set] <= touch_way;
        end
    end
endmodule

// File: rtl/sc_lookup.sv
// Module: sc_lookup
// Combinational compare of one set against a request: tag match per way,
// mask of demanded-but-invalid words, and victim choice.
// Assumes WAYS is a power of two and tags are unique within a set.
module sc_lookup
    import sc_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int TAG_W = 22,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tag,
    input  logic [WAYS-1:0][SECT-1:0]  set_val,
    input  logic [WAYS-1:0]            set_line,
    input  logic [WAY_W-1:0]           set_mru,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [SECT-1:0]            req_sect,
    output logic                       tag_hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [SECT-1:0]            missing,
    output logic [WAY_W-1:0]           victim_way
);
    logic [WAYS-1:0] match;

    // Purpose: per-way tag comparison against present lines.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_line[w] && (set_tag[w] == req_tag);
    end

    // Purpose: encode matching way and derive the missing-word mask.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
        tag_hit = |match;
        missing = req_sect & ~set_val[hit_way];
    end

    // Purpose: pick lowest empty way, else the way after the MRU one.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = set_mru + WAY_W'(1);
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !set_line[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sc_ctrl.sv
// Module: sc_ctrl
// Accepts requests, registers the outcome, holds the single outstanding
// miss and turns the fill response into a store write.
// Assumes the lookup result refers to the set addressed by req_set.
module sc_ctrl
    import sc_pkg::*;
#(
    parameter int TAG_W = 22,
    parameter int SET_W = 4,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [SET_W-1:0] req_set,
    input  logic [SECT-1:0]  req_sect,
    output logic             req_ready,
    input  logic             lk_tag_hit,
    input  logic [WAY_W-1:0] lk_hit_way,
    input  logic [SECT-1:0]  lk_missing,
    input  logic [WAY_W-1:0] lk_victim,
    input  logic             fill_valid,
    input  logic [SECT-1:0]  fill_sect,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_sect_miss,
    output logic             rsp_full_miss,
    output logic [SECT-1:0]  rsp_fetch,
    output logic             wr_en,
    output logic             wr_replace,
    output logic [SET_W-1:0] wr_set,
    output logic [WAY_W-1:0] wr_way,
    output logic [TAG_W-1:0] wr_tag,
    output logic [SECT-1:0]  wr_sect,
    output logic             touch_en,
    output logic [SET_W-1:0] touch_set,
    output logic [WAY_W-1:0] touch_way
);
    sc_state_e        state_q;
    logic [SET_W-1:0] pend_set_q;
    logic [TAG_W-1:0] pend_tag_q;
    logic [WAY_W-1:0] pend_way_q;
    logic             pend_full_q;
    logic             accept;
    logic             full_hit;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign full_hit  = lk_tag_hit && (lk_missing == '0);

    // Purpose: state, pending-miss record and registered outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            pend_set_q    <= '0;
            pend_tag_q    <= '0;
            pend_way_q    <= '0;
            pend_full_q   <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_sect_miss <= 1'b0;
            rsp_full_miss <= 1'b0;
            rsp_fetch     <= '0;
        end else begin
            rsp_valid     <= accept;
            rsp_hit       <= accept && full_hit;
            rsp_sect_miss <= accept && lk_tag_hit && !full_hit;
            rsp_full_miss <= accept && !lk_tag_hit;
            if (accept) begin
                rsp_fetch <= lk_tag_hit ? lk_missing : req_sect;
            end else begin
                rsp_fetch <= '0;
            end
            if (accept && !full_hit) begin
                state_q     <= ST_WAIT;
                pend_set_q  <= req_set;
                pend_tag_q  <= req_tag;
                pend_way_q  <= lk_tag_hit ? lk_hit_way : lk_victim;
                pend_full_q <= !lk_tag_hit;
            end else if (state_q == ST_WAIT && fill_valid) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // Purpose: drive the store write and touch ports.
    always_comb begin
        wr_en      = (state_q == ST_WAIT) && fill_valid;
        wr_replace = pend_full_q;
        wr_set     = pend_set_q;
        wr_way     = pend_way_q;
        wr_tag     = pend_tag_q;
        wr_sect    = fill_sect;
        touch_en   = accept && full_hit;
        touch_set  = req_set;
        touch_way  = lk_hit_way;
    end
endmodule

// File: rtl/sector_cache_lookup.sv
// Module: sector_cache_lookup (top)
// Tag lookup and fill control for a set-associative cache with eight
// per-word valid bits per 512-bit line. One outstanding miss at a time.
// Assumes SETS and WAYS are powers of two; address bits [5:0] are ignored.
module sector_cache_lookup
    import sc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SECT-1:0]   req_sect,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_sect_miss,
    output logic              rsp_full_miss,
    output logic [SECT-1:0]   rsp_fetch,
    input  logic              fill_valid,
    input  logic [SECT-1:0]   fill_sect
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W - OFFSET_W;

    logic [SET_W-1:0]           a_set;
    logic [TAG_W-1:0]           a_tag;
    logic [WAYS-1:0][TAG_W-1:0] s_tag;
    logic [WAYS-1:0][SECT-1:0]  s_val;
    logic [WAYS-1:0]            s_line;
    logic [WAY_W-1:0]           s_mru;
    logic                       lk_tag_hit;
    logic [WAY_W-1:0]           lk_hit_way;
    logic [SECT-1:0]            lk_missing;
    logic [WAY_W-1:0]           lk_victim;
    logic                       wr_en, wr_replace, touch_en;
    logic [SET_W-1:0]           wr_set, touch_set;
    logic [WAY_W-1:0]           wr_way, touch_way;
    logic [TAG_W-1:0]           wr_tag;
    logic [SECT-1:0]            wr_sect;

    // Purpose: split the address into set index and tag.
    if (SETS > 1) begin : g_idx
        assign a_set = req_addr[OFFSET_W +: IDX_W];
    end else begin : g_noidx
        assign a_set = '0;
    end
    assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

    sc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_store (
        .clk(clk), .rst_n(rst_n), .rd_set(a_set),
        .rd_tag(s_tag), .rd_val(s_val), .rd_line(s_line), .rd_mru(s_mru),
        .wr_en(wr_en), .wr_replace(wr_replace), .wr_set(wr_set),
        .wr_way(wr_way), .wr_tag(wr_tag), .wr_sect(wr_sect),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way)
    );

    sc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lookup (
        .set_tag(s_tag), .set_val(s_val), .set_line(s_line), .set_mru(s_mru),
        .req_tag(a_tag), .req_sect(req_sect),
        .tag_hit(lk_tag_hit), .hit_way(lk_hit_way),
        .missing(lk_missing), .victim_way(lk_victim)
    );

    sc_ctrl #(.TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tag(a_tag), .req_set(a_set),
        .req_sect(req_sect), .req_ready(req_ready),
        .lk_tag_hit(lk_tag_hit), .lk_hit_way(lk_hit_way),
        .lk_missing(lk_missing), .lk_victim(lk_victim),
        .fill_valid(fill_valid), .fill_sect(fill_sect),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_sect_miss(rsp_sect_miss), .rsp_full_miss(rsp_full_miss),
        .rsp_fetch(rsp_fetch),
        .wr_en(wr_en), .wr_replace(wr_replace), .wr_set(wr_set),
        .wr_way(wr_way), .wr_tag(wr_tag), .wr_sect(wr_sect),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way)
    );
endmodule

// File: rtl/sc_checker.sv
// Module: sc_checker
// Protocol and outcome properties for sector_cache_lookup, bound to it.
// Assumes fills are only given while a miss is outstanding.
module sc_checker
    import sc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [SECT-1:0] req_sect,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_sect_miss,
    input logic            rsp_full_miss,
    input logic [SECT-1:0] rsp_fetch,
    input logic            fill_valid
);
    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_sect_miss, rsp_full_miss}));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_sect_miss || rsp_full_miss));

    assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_fetch == '0));

    assert_fetch_within_demand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_fetch & ~$past(req_sect)) == '0));

    assert_sect_miss_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sect_miss |-> (rsp_fetch != '0));

    assert_full_miss_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full_miss |-> (rsp_fetch == $past(req_sect)));

    assert_miss_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sect_miss || rsp_full_miss) |-> !req_ready);

    assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !fill_valid) |=> !req_ready);

    assert_fill_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && fill_valid) |=> req_ready);
endmodule

bind sector_cache_lookup sc_checker i_sc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sect(req_sect), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_sect_miss(rsp_sect_miss), .rsp_full_miss(rsp_full_miss),
    .rsp_fetch(rsp_fetch), .fill_valid(fill_valid)
);

// File: tb/test_sector_cache_lookup.sv
module test_sector_cache_lookup;
    localparam int ADDR_W = 16;
    localparam int SETS   = 4;
    localparam int WAYS   = 2;
    localparam int TAG_W  = ADDR_W - 2 - 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_sect = '0;
    logic              rsp_valid, rsp_hit, rsp_sect_miss, rsp_full_miss;
    logic [7:0]        rsp_fetch;
    logic              fill_valid = 1'b0;
    logic [7:0]        fill_sect = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench model of the cache contents, driven only by the requirements.
    logic [TAG_W-1:0] m_tag  [SETS][WAYS];
    logic [7:0]       m_val  [SETS][WAYS];
    bit               m_line [SETS][WAYS];
    int               m_mru  [SETS];

    sector_cache_lookup #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) i_sector_cache_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_sect(req_sect), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_sect_miss(rsp_sect_miss),
        .rsp_full_miss(rsp_full_miss), .rsp_fetch(rsp_fetch),
        .fill_valid(fill_valid), .fill_sect(fill_sect)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One lookup; on a miss, an extra stalled request then a fill.
    task automatic lookup(input int tag, input int set, input logic [7:0] d,
                          input logic [7:0] fm);
        int  hw;
        int  kind;
        int  vw;
        logic [7:0] exp_mask;
        string rq;
        hw = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_line[set][w] && m_tag[set][w] == TAG_W'(tag)) hw = w;
        if (hw < 0) begin
            kind = 2; exp_mask = d; rq = "R5";
        end else if ((d & ~m_val[set][hw]) == 8'h00) begin
            kind = 0; exp_mask = 8'h00; rq = "R3";
        end else begin
            kind = 1; exp_mask = d & ~m_val[set][hw]; rq = "R4";
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {TAG_W'(tag), 2'(set), 6'($urandom_range(0, 63))};
        req_sect  = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
        chk({rsp_hit, rsp_sect_miss, rsp_full_miss} === 3'b100 >> kind, rq,
            int'({rsp_hit, rsp_sect_miss, rsp_full_miss}), int'(3'b100 >> kind));
        chk(rsp_fetch === exp_mask, rq, int'(rsp_fetch), int'(exp_mask));
        if (kind == 0) begin
            m_mru[set] = hw;
        end else begin
            chk(req_ready === 1'b0, "R6 stall", int'(req_ready), 0);
            req_valid = 1'b1;
            req_addr  = {TAG_W'(tag + 1), 2'(set), 6'd0};
            @(negedge clk);
            chk(rsp_valid === 1'b0, "R6 no rsp in stall", int'(rsp_valid), 0);
            chk(req_ready === 1'b0, "R6 stall held", int'(req_ready), 0);
            req_valid  = 1'b0;
            fill_valid = 1'b1;
            fill_sect  = fm;
            @(negedge clk);
            fill_valid = 1'b0;
            chk(req_ready === 1'b1, "R6 release", int'(req_ready), 1);
            if (kind == 1) begin
                m_val[set][hw] = m_val[set][hw] | fm;      // R7
                m_mru[set] = hw;
            end else begin
                vw = -1;
                for (int w = WAYS - 1; w >= 0; w--)
                    if (!m_line[set][w]) vw = w;
                if (vw < 0) vw = (m_mru[set] + 1) % WAYS;  // R9
                m_tag[set][vw]  = TAG_W'(tag);             // R8
                m_val[set][vw]  = fm;
                m_line[set][vw] = 1'b1;
                m_mru[set] = vw;
            end
        end
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_mru[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = '0; m_val[s][w] = '0; m_line[s][w] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        // R5, R8: full miss on empty set, install with returned mask
        lookup(8'h11, 1, 8'h05, 8'h05);
        lookup(8'h11, 1, 8'h05, 8'h00);   // R3 hit
        // R4, R7: partial miss then merge
        lookup(8'h11, 1, 8'h0F, 8'h0A);
        lookup(8'h11, 1, 8'h0F, 8'h00);   // R7 merged, now a hit
        // Exhaustive demand sweep, fills carry nothing so state holds
        for (int d = 0; d < 256; d++) lookup(8'h11, 1, 8'(d), 8'h00);
        // R10: stray fill while idle must not touch the line
        @(negedge clk);
        fill_valid = 1'b1; fill_sect = 8'hFF;
        @(negedge clk);
        fill_valid = 1'b0;
        chk(rsp_valid === 1'b0, "R10 no rsp", int'(rsp_valid), 0);
        chk(req_ready === 1'b1, "R10 ready", int'(req_ready), 1);
        lookup(8'h11, 1, 8'hFF, 8'h00);   // R10 expect fetch F0
        // R11: same tag in another set is independent
        lookup(8'h11, 2, 8'h01, 8'hFF);
        lookup(8'h11, 2, 8'hFF, 8'h00);
        // R9: fill both ways, touch A, third tag evicts B
        lookup(8'hA0, 3, 8'h01, 8'h01);
        lookup(8'hB0, 3, 8'h01, 8'h01);
        lookup(8'hA0, 3, 8'h01, 8'h00);
        lookup(8'hC0, 3, 8'h01, 8'h01);
        lookup(8'hA0, 3, 8'h01, 8'h00);   // R9 A kept
        lookup(8'hB0, 3, 8'h01, 8'h01);   // R9 B evicted: full miss
        // Mixed sweep over all sets and a small tag pool
        for (int i = 0; i < 1500; i++)
            lookup($urandom_range(0, 3), $urandom_range(0, 3),
                   8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule